// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Sequencer

This block runs one logic-analyzer acquisition at a time. A control write of the run command clears the sample counters and starts filling memory with the pre-trigger history. Once the programmed number of pre-trigger samples has been stored, the block keeps sampling and waits for a trigger pulse. The first trigger pulse it accepts starts the post-trigger phase. When the post-trigger quota (sample limit minus pre-trigger count) has been stored, the block returns to idle on its own. A halt write ends a run in any phase.

Progress is shown in a 16-bit status word. Its low nibble encodes the phase. Its upper twelve bits are a fixed tag that host software reads to confirm the expected configuration is loaded. Every accepted sample raises a memory write enable. The block also reports two values: the number of samples stored in the run, and the sample count at which the trigger was accepted. Software uses these to locate the trigger point in memory after the run.

Top module: `capture_seq`

## Requirements
- R1: After reset the status word is 0x85E9 and reads 0x85E9 whenever the block is idle. Status bits [15:4] always read 0x85E.
- R2: A control write of 0x03 while idle starts a run and clears both reports to 0. The status low nibble becomes 0x2 when the pre-trigger count is non-zero. It becomes 0xA when the pre-trigger count is zero, so the pre-trigger phase is skipped.
- R3: In the pre-trigger phase (nibble 0x2), the block moves to the waiting phase (nibble 0xA) in the cycle after the sample that brings the stored count to the pre-trigger count.
- R4: A trigger pulse during the pre-trigger phase is ignored. The phase and the final trigger position are unchanged by it.
- R5: In the waiting phase a trigger pulse is accepted. The status nibble becomes 0xE, and the trigger position report latches the number of samples stored up to and including the trigger cycle.
- R6: In the post-trigger phase, after limit minus pre-trigger count further samples, the block returns to idle (status bits [1:0] = 01). The captured report then equals trigger position plus that quota.
- R7: When the sample limit is less than or equal to the pre-trigger count, an accepted trigger returns the block straight to idle.
- R8: The memory write enable follows the sample strobe while a run is active (status bit 1 set) and is 0 while idle. The captured report counts each write.
- R9: A control write of 0x00 returns the block to idle by the next clock from any phase. Both reports keep their values.
- R10: A control write of any other value is ignored, and so is a 0x03 write during a run. Neither changes the phase or the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Run-control write strobe |
| ctl_data | input | 8 | Run-control value: 0x03 run, 0x00 halt |
| smp_en | input | 1 | Sample strobe, one sample per high cycle |
| trig_in | input | 1 | Trigger pulse from the trigger matcher |
| smp_limit | input | CNT_W | Total samples wanted (pre plus post) |
| pre_count | input | CNT_W | Pre-trigger samples wanted |
| status | output | 16 | Tag in [15:4], phase code in [3:0] |
| mem_we | output | 1 | Sample memory write enable |
| captured | output | CNT_W | Samples stored in the current or last run |
| trig_pos | output | CNT_W | Stored-sample count when the trigger was accepted |

## Verification
The bench goes after the phase boundaries. A zero pre-trigger count must skip straight to waiting, and a sequencer that entered the pre-trigger phase anyway would hang there. With a sample limit no larger than the pre-trigger count, a block that entered the post-trigger phase would never finish. An early trigger during pre-fill is sent to catch a design that accepts it and reports a wrong trigger position. Halt in mid-run, a run write during a run, and a stray control value are checked to catch counters that get cleared or a phase that wrongly changes.

// File: rtl/capture_seq_pkg.sv
// Shared types and constants for the capture sequencer.
// Assumes: status tag and phase codes are fixed by host software.
package capture_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_WAIT = 2'd2,
        ST_POST = 2'd3
    } seq_state_e;

    localparam logic [11:0] STAT_TAG = 12'h85E;
    localparam logic [7:0]  CMD_RUN  = 8'h03;
    localparam logic [7:0]  CMD_HALT = 8'h00;

    // Phase code: bit0 idle, bit1 writing, bit2 trigger seen, bit3 pre-fill done
    function automatic logic [3:0] phase_code(seq_state_e s);
        logic [3:0] c;
        case (s)
            ST_PRE:  c = 4'h2;
            ST_WAIT: c = 4'hA;
            ST_POST: c = 4'hE;
            default: c = 4'h9;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/capture_seq_fsm.sv
// Phase controller of the capture sequencer.
// Does: holds the run phase and flags accepted start and trigger events.
// Assumes: halt has priority over every other event; only the first
// trigger seen in the waiting phase is accepted.
module capture_seq_fsm
    import capture_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       smp_en,
    input  logic       trig_in,
    input  logic       pre_zero,
    input  logic       pre_hit,
    input  logic       post_zero,
    input  logic       post_hit,
    output seq_state_e state,
    output logic       start_acc,
    output logic       trig_acc
);

    seq_state_e state_nx;

    // Event qualification: start only from idle, trigger only while waiting
    always_comb begin
        start_acc = (state == ST_IDLE) && start_req && !stop_req;
        trig_acc  = (state == ST_WAIT) && trig_in && !stop_req;
    end

    // Next-phase selection
    always_comb begin
        state_nx = state;
        if (stop_req) begin
            state_nx = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start_req) state_nx = pre_zero ? ST_WAIT : ST_PRE;
                ST_PRE:  if (smp_en && pre_hit) state_nx = ST_WAIT;
                ST_WAIT: if (trig_in) state_nx = post_zero ? ST_IDLE : ST_POST;
                ST_POST: if (smp_en && post_hit) state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/capture_seq_cnt.sv
// Sample counters of the capture sequencer.
// Does: counts stored samples and post-trigger samples, latches the
// trigger position and compares the counts against their targets.
// Assumes: start_acc never coincides with a write (it is taken only in idle).
module capture_seq_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_acc,
    input  logic             trig_acc,
    input  logic             we,
    input  logic             post_smp,
    input  logic [CNT_W-1:0] pre_count,
    input  logic [CNT_W-1:0] smp_limit,
    output logic [CNT_W-1:0] captured,
    output logic [CNT_W-1:0] trig_pos,
    output logic             pre_zero,
    output logic             pre_hit,
    output logic             post_zero,
    output logic             post_hit
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] post_cnt;
    logic [CNT_W-1:0] post_tgt;
    logic [EXT_W-1:0] cap_inc;
    logic [EXT_W-1:0] post_inc;

    // Target and threshold compares, widened by one bit against wrap
    always_comb begin
        post_tgt  = (smp_limit > pre_count) ? (smp_limit - pre_count) : '0;
        cap_inc   = {1'b0, captured} + EXT_W'(1);
        post_inc  = {1'b0, post_cnt} + EXT_W'(1);
        pre_zero  = (pre_count == '0);
        post_zero = (post_tgt == '0);
        pre_hit   = cap_inc >= {1'b0, pre_count};
        post_hit  = post_inc >= {1'b0, post_tgt};
    end

    // Stored-sample count
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) captured <= '0;
        else if (we)             captured <= cap_inc[CNT_W-1:0];
    end

    // Post-trigger sample count
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) post_cnt <= '0;
        else if (post_smp)       post_cnt <= post_inc[CNT_W-1:0];
    end

    // Trigger position latch, including a sample taken in the trigger cycle
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) trig_pos <= '0;
        else if (trig_acc)       trig_pos <= we ? cap_inc[CNT_W-1:0] : captured;
    end

endmodule

// File: rtl/capture_seq.sv
// Top of the pre/post-trigger capture sequencer.
// Does: decodes run-control writes, sequences pre-fill, trigger wait and
// post-trigger capture, and presents status, write enable and reports.
// Assumes: smp_en and trig_in are synchronous to clk.
module capture_seq
    import capture_seq_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_data,
    input  logic             smp_en,
    input  logic             trig_in,
    input  logic [CNT_W-1:0] smp_limit,
    input  logic [CNT_W-1:0] pre_count,
    output logic [15:0]      status,
    output logic             mem_we,
    output logic [CNT_W-1:0] captured,
    output logic [CNT_W-1:0] trig_pos
);

    seq_state_e state;
    logic start_req, stop_req, start_acc, trig_acc;
    logic pre_zero, pre_hit, post_zero, post_hit;

    // Control-write decode and output formation
    always_comb begin
        start_req = ctl_wr && (ctl_data == CMD_RUN);
        stop_req  = ctl_wr && (ctl_data == CMD_HALT);
        mem_we    = smp_en && (state != ST_IDLE);
        status    = {STAT_TAG, phase_code(state)};
    end

    capture_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .smp_en    (smp_en),
        .trig_in   (trig_in),
        .pre_zero  (pre_zero),
        .pre_hit   (pre_hit),
        .post_zero (post_zero),
        .post_hit  (post_hit),
        .state     (state),
        .start_acc (start_acc),
        .trig_acc  (trig_acc)
    );

    capture_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .trig_acc  (trig_acc),
        .we        (mem_we),
        .post_smp  (smp_en && (state == ST_POST)),
        .pre_count (pre_count),
        .smp_limit (smp_limit),
        .captured  (captured),
        .trig_pos  (trig_pos),
        .pre_zero  (pre_zero),
        .pre_hit   (pre_hit),
        .post_zero (post_zero),
        .post_hit  (post_hit)
    );

endmodule

// File: rtl/capture_seq_chk.sv
// Assertion checker for capture_seq, attached by bind.
// Does: checks status tag, halt, trigger, pre-fill hold and write counting.
module capture_seq_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic [7:0]       ctl_data,
    input logic             smp_en,
    input logic             trig_in,
    input logic [15:0]      status,
    input logic             mem_we,
    input logic [CNT_W-1:0] captured,
    input logic [CNT_W-1:0] trig_pos
);

    logic halt_wr;
    always_comb halt_wr = ctl_wr && (ctl_data == 8'h00);

    p_tag_const_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status[15:4] == 12'h85E);

    p_halt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_wr |=> status[3:0] == 4'h9);

    p_pre_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:0] == 4'h2 && !smp_en && !ctl_wr) |=> status[3:0] == 4'h2);

    p_trig_leave_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:0] == 4'hA && trig_in && !halt_wr) |=> status[3:0] != 4'hA);

    p_post_pos_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:0] == 4'hE && !ctl_wr) |=> trig_pos == $past(trig_pos));

    p_no_we_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> !mem_we);

    p_we_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> captured == $past(captured) + CNT_W'(1));

endmodule

bind capture_seq capture_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_data (ctl_data),
    .smp_en   (smp_en),
    .trig_in  (trig_in),
    .status   (status),
    .mem_we   (mem_we),
    .captured (captured),
    .trig_pos (trig_pos)
);

// File: tb/tb_capture_seq.sv
// Self-checking bench for capture_seq: table-driven runs, then directed cases.
module tb_capture_seq;

    localparam int CNT_W = 32;
    localparam int NV = 6;
    // {pre_count, smp_limit, samples waited before trigger sample}
    localparam int unsigned VEC [0:NV-1][0:2] = '{
        '{4, 10, 2},
        '{0,  5, 0},
        '{1,  1, 3},
        '{3,  8, 0},
        '{6,  6, 1},
        '{2, 20, 5}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [7:0]       ctl_data = 8'h00;
    logic             smp_en = 1'b0;
    logic             trig_in = 1'b0;
    logic [CNT_W-1:0] smp_limit = '0;
    logic [CNT_W-1:0] pre_count = '0;
    logic [15:0]      status;
    logic             mem_we;
    logic [CNT_W-1:0] captured;
    logic [CNT_W-1:0] trig_pos;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    capture_seq #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .smp_en(smp_en), .trig_in(trig_in), .smp_limit(smp_limit),
        .pre_count(pre_count), .status(status), .mem_we(mem_we),
        .captured(captured), .trig_pos(trig_pos)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl(input logic [7:0] v);
        ctl_wr = 1'b1;
        ctl_data = v;
        tick();
        ctl_wr = 1'b0;
        ctl_data = 8'h00;
    endtask

    task automatic samp(input logic t);
        smp_en = 1'b1;
        trig_in = t;
        tick();
        smp_en = 1'b0;
        trig_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset status", status, 16'h85E9);
        chk("R8 no write after reset", mem_we, 0);

        // Table-driven runs
        for (int v = 0; v < NV; v++) begin
            int unsigned p = VEC[v][0];
            int unsigned l = VEC[v][1];
            int unsigned w = VEC[v][2];
            int unsigned q = (l > p) ? l - p : 0;
            pre_count = p;
            smp_limit = l;
            ctl(8'h03);
            chk("R2 start phase", status, (p == 0) ? 16'h85EA : 16'h85E2);
            chk("R2 captured cleared", captured, 0);
            for (int i = 0; i < int'(p); i++) begin
                if (i == 0) begin
                    smp_en = 1'b1;
                    #1 chk("R8 write enable in run", mem_we, 1);
                end
                samp(1'b0);
            end
            chk("R3 pre-fill done", status, 16'h85EA);
            for (int i = 0; i < int'(w); i++) samp(1'b0);
            chk("R3 still waiting", status, 16'h85EA);
            samp(1'b1);
            chk("R5 trigger position", trig_pos, p + w + 1);
            if (q == 0) begin
                chk("R7 straight to idle", status, 16'h85E9);
            end else begin
                chk("R5 post phase", status, 16'h85EE);
                for (int i = 0; i < int'(q); i++) samp(1'b0);
                chk("R6 complete idle", status, 16'h85E9);
            end
            chk("R6 captured total", captured, p + w + 1 + q);
        end

        // Directed: early trigger during pre-fill is ignored
        pre_count = 3;
        smp_limit = 5;
        ctl(8'h03);
        samp(1'b1);
        chk("R4 early trigger ignored", status, 16'h85E2);
        trig_in = 1'b1;
        tick();
        trig_in = 1'b0;
        chk("R4 trigger without sample ignored", status, 16'h85E2);
        samp(1'b0);
        samp(1'b0);
        chk("R4 reaches wait", status, 16'h85EA);
        samp(1'b1);
        chk("R4 trigger position unaffected", trig_pos, 4);

        // Directed: run write during run and stray value ignored
        ctl(8'h03);
        chk("R10 run write during run", status, 16'h85EE);
        chk("R10 counts kept", captured, 4);
        ctl(8'h05);
        chk("R10 stray value", status, 16'h85EE);

        // Directed: halt during post phase
        ctl(8'h00);
        chk("R9 halt to idle", status, 16'h85E9);
        chk("R9 captured held", captured, 4);
        chk("R9 trig_pos held", trig_pos, 4);

        // Directed: samples in idle do nothing; stray value in idle
        smp_en = 1'b1;
        #1 chk("R8 no write in idle", mem_we, 0);
        tick();
        smp_en = 1'b0;
        chk("R8 idle sample not counted", captured, 4);
        ctl(8'h07);
        chk("R10 stray value in idle", status, 16'h85E9);

        // Directed: halt during waiting phase
        pre_count = 0;
        smp_limit = 4;
        ctl(8'h03);
        samp(1'b0);
        ctl(8'h00);
        chk("R9 halt from wait", status, 16'h85E9);
        chk("R9 count held after wait halt", captured, 1);

        // Directed: reset mid-run
        pre_count = 2;
        ctl(8'h03);
        samp(1'b0);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R1 reset mid-run", status, 16'h85E9);
        chk("R1 reset clears count", captured, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule